// File: doc/BRIEF.md
# Triple Down-Counter Timer

This block holds three independent down-counting timers behind one register window. Each timer sits in its own 0x100-byte slot and has a reload value, a control byte, a readable current count, raw and masked interrupt status and an interrupt clear. Counting advances only on cycles where that timer's own tick enable is high, and a per-timer prescaler can divide those ticks by 16 or 256. Each timer drives one interrupt line.

Each timer is built around a three-state machine. The states are OFF (disabled), RUN (counting) and DONE (a one-shot count has expired). The transitions are:
- OFF to RUN: a control write sets the enable bit.
- OFF to DONE: a control write enables one-shot mode while the stored count is zero.
- RUN to OFF: a control write clears the enable bit.
- RUN to DONE: an expiry in one-shot mode.
- DONE to RUN: a load write, or a control write that keeps the enable bit and clears one-shot.
- DONE to OFF: a control write that clears the enable bit.

On expiry, a RUN timer reloads in one of three ways. In periodic mode it takes the stored reload value. In free-running mode it takes all ones at the selected width. In one-shot mode it parks at zero.

Top module: `tri_timer`

## Requirements
- R1: After reset every control byte reads 0x20, raw status reads 0, the current value reads 0, and the internal count holds all ones. Enabling a timer in 32-bit mode without ticks then shows 0xFFFFFFFF.
- R2: With prescale code 00, a RUN timer's count drops by one on every cycle where its tick enable is high, and holds otherwise.
- R3: Control bits 3:2 select the prescale. Code 01 makes one count step every 16 ticks and code 10 every 256 ticks. A load or control write restarts the prescaler.
- R4: In free-running mode (bits 6 and 0 clear), expiry reloads 0xFFFFFFFF when bit 1 is set and 0xFFFF when bit 1 is clear. In 16-bit mode only the low 16 bits count and are read back.
- R5: In periodic mode (bit 6 set, bit 0 clear), expiry reloads the stored reload value.
- R6: In one-shot mode (bit 0 set), expiry leaves the count at zero in DONE. Further ticks neither count nor set the raw status. A load write restarts the count.
- R7: Expiry is the step taken from a count of 1 (or 0). It sets raw status (word 4, bit 0). Any write to word 3 clears raw status.
- R8: Masked status (word 5) and the timer's irq line equal raw status AND control bit 5.
- R9: Writing word 0 sets both the reload value and the count at once. Writing word 6 sets only the reload value, which is used at the next periodic expiry. Words 0 and 6 read back the reload value.
- R10: While a timer is OFF its current value (word 1) reads 0, and its count is held. Re-enabling it shows the held count again.
- R11: Writes to word 1 are ignored.
- R12: Timer n is decoded at byte offset n*0x100 with word w at w*4. Each timer counts only on its own tick enable bit, and accesses to one timer leave the others unchanged.
- R13: Word 2 reads back the 8-bit control value last written (bit 7 enable, 6 periodic, 5 interrupt enable, 3:2 prescale, 1 wide, 0 one-shot).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (12) | Byte address: bits 9:8 pick the timer, bits 4:2 the word |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| tick_en | input | NUM_TIMERS (3) | Per-timer count tick enable |
| irq | output | NUM_TIMERS (3) | Per-timer interrupt request |

## Verification
The hardest situation to reach from the ports is the DONE state after a one-shot expiry. The bench must show that further ticks are truly inert, which means neither the count nor the raw flag moves, and then that a load write revives the timer. The stimulus clears the raw flag after the one-shot expiry and keeps ticking. Any stray step or interrupt then shows up as a nonzero readback. The 256-tick prescale boundary is reached by holding the tick enable for exactly 255 cycles and then for one more.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_e;

    // control byte bit positions
    localparam int CB_ENA  = 7;
    localparam int CB_PER  = 6;
    localparam int CB_IE   = 5;
    localparam int CB_PSHI = 3;
    localparam int CB_PSLO = 2;
    localparam int CB_WIDE = 1;
    localparam int CB_ONE  = 0;

    localparam logic [7:0] CTRL_RESET = 8'h20;

    // register word indices within a timer slot
    localparam logic [2:0] W_LOAD  = 3'd0;
    localparam logic [2:0] W_VALUE = 3'd1;
    localparam logic [2:0] W_CTRL  = 3'd2;
    localparam logic [2:0] W_ICLR  = 3'd3;
    localparam logic [2:0] W_RAW   = 3'd4;
    localparam logic [2:0] W_MASK  = 3'd5;
    localparam logic [2:0] W_BGLD  = 3'd6;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       step
);
    localparam int PRE_W = DIV_B_LOG;
    localparam logic [PRE_W-1:0] LIM_A = PRE_W'((1 << DIV_A_LOG) - 1);
    localparam logic [PRE_W-1:0] LIM_B = PRE_W'((1 << DIV_B_LOG) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        unique case (code)
            2'b01:   limit = LIM_A;
            2'b10:   limit = LIM_B;
            default: limit = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            if (pre_q == limit) pre_q <= '0;
            else                pre_q <= pre_q + 1'b1;
        end
    end

    assign step = run && tick && !restart && (pre_q == limit);

    // R3
    pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= limit);

    // R3
    pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (pre_q == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tri_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       word,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONES_WIDE = '1;
    localparam logic [CNT_W-1:0] ONES_HALF = {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};

    tmr_state_e       st_q, st_d;
    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_q;
    logic             raw_q;

    logic wr_load, wr_ctrl, wr_iclr, wr_bg;
    logic step, expire_now;
    logic [CNT_W-1:0] eff;

    assign wr_load = wr_en && (word == W_LOAD);
    assign wr_ctrl = wr_en && (word == W_CTRL);
    assign wr_iclr = wr_en && (word == W_ICLR);
    assign wr_bg   = wr_en && (word == W_BGLD);

    assign eff = ctrl_q[CB_WIDE] ? cnt_q : {{(CNT_W-HALF){1'b0}}, cnt_q[HALF-1:0]};

    tmr_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_RUN),
        .tick    (tick),
        .restart (wr_load || wr_ctrl),
        .code    (ctrl_q[CB_PSHI:CB_PSLO]),
        .step    (step)
    );

    assign expire_now = step && (eff <= CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (wr_ctrl && wdata[CB_ENA])
                    st_d = (wdata[CB_ONE] && cnt_q == '0) ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (wr_ctrl && !wdata[CB_ENA])  st_d = ST_OFF;
                else if (wr_ctrl)               st_d = ST_RUN;
                else if (expire_now && ctrl_q[CB_ONE]) st_d = ST_DONE;
            end
            ST_DONE: begin
                if (wr_ctrl && !wdata[CB_ENA])     st_d = ST_OFF;
                else if (wr_ctrl && !wdata[CB_ONE]) st_d = ST_RUN;
                else if (wr_load)                  st_d = ST_RUN;
            end
            default: st_d = ST_OFF;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            cnt_q  <= ONES_WIDE;
            load_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[7:0];
            if (wr_load || wr_bg) load_q <= wdata;
            if (wr_load) begin
                cnt_q <= wdata;
            end else if (step) begin
                if (eff <= CNT_W'(1)) begin
                    if (ctrl_q[CB_ONE])      cnt_q <= '0;
                    else if (ctrl_q[CB_PER]) cnt_q <= load_q;
                    else if (ctrl_q[CB_WIDE]) cnt_q <= ONES_WIDE;
                    else                     cnt_q <= ONES_HALF;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (expire_now)   raw_q <= 1'b1;
            else if (wr_iclr) raw_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        rdata = '0;
        unique case (word)
            W_LOAD, W_BGLD: rdata = load_q;
            W_VALUE:        rdata = (st_q == ST_RUN) ? eff : '0;
            W_CTRL:         rdata = {{(CNT_W-8){1'b0}}, ctrl_q};
            W_RAW:          rdata = {{(CNT_W-1){1'b0}}, raw_q};
            W_MASK:         rdata = {{(CNT_W-1){1'b0}}, raw_q & ctrl_q[CB_IE]};
            default:        rdata = '0;
        endcase
    end

    assign irq = raw_q & ctrl_q[CB_IE];

    // R2
    step_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (st_q == ST_RUN));

    // R7
    raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(step));

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !wr_en) |=> (cnt_q == '0 && !$rose(raw_q)));

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_load) |=> $stable(cnt_q));

    // R10
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[CB_ENA]) |=> (st_q == ST_OFF));

endmodule

// File: rtl/tri_timer.sv
module tri_timer #(
    parameter int NUM_TIMERS = 3,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    output logic [CNT_W-1:0]      bus_rdata,
    input  logic [NUM_TIMERS-1:0] tick_en,
    output logic [NUM_TIMERS-1:0] irq
);
    localparam int SLOT_LSB = 8;
    localparam int IDX_W    = ADDR_W - SLOT_LSB;

    logic [IDX_W-1:0] idx;
    logic [2:0]       word;
    logic             pad_ok;
    logic [NUM_TIMERS-1:0] hit;
    logic [CNT_W-1:0] ch_rd [NUM_TIMERS];

    assign idx    = bus_addr[ADDR_W-1:SLOT_LSB];
    assign word   = bus_addr[4:2];
    assign pad_ok = (bus_addr[SLOT_LSB-1:5] == '0) && (bus_addr[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        assign hit[g] = pad_ok && (idx == IDX_W'(g));
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_en[g]),
            .wr_en (bus_wr && hit[g]),
            .word  (word),
            .wdata (bus_wdata),
            .rdata (ch_rd[g]),
            .irq   (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_TIMERS; k++)
            if (hit[k]) bus_rdata = ch_rd[k];
    end

    // R12
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/test_tri_timer.sv
module test_tri_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  tick_en = '0;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tri_timer i_tri_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int t, input int w, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 12'(t * 256 + w * 4);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int t, input int w, output logic [31:0] d);
        bus_addr = 12'(t * 256 + w * 4);
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input logic [2:0] m, input int n);
        @(negedge clk);
        tick_en = m;
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int t = 0; t < 3; t++) begin
            rd(t, 2, v); chk("R1 ctrl reset", v, 32'h20);
            rd(t, 4, v); chk("R1 raw reset", v, 0);
            rd(t, 1, v); chk("R1 value reads 0 when off", v, 0);
        end
        wr(2, 2, 32'hA2);
        rd(2, 1, v); chk("R1 count resets to all ones", v, 32'hFFFF_FFFF);
        wr(2, 2, 32'h20);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(0, 2, 32'hE2);
        wr(0, 0, 10);
        rd(0, 1, v); chk("R9 load sets count", v, 10);
        ticks(3'b001, 3);
        rd(0, 1, v); chk("R2 decrement per tick", v, 7);
        ticks(3'b001, 6);
        rd(0, 1, v); chk("R2 count at one", v, 1);
        rd(0, 4, v); chk("R7 no raw before expiry", v, 0);
        ticks(3'b001, 1);
        rd(0, 1, v); chk("R5 periodic reload", v, 10);
        rd(0, 4, v); chk("R7 raw on expiry", v, 1);
        rd(0, 5, v); chk("R8 masked with ie", v, 1);
        chk("R8 irq0 high", {31'b0, irq[0]}, 1);
        wr(0, 3, 0);
        rd(0, 4, v); chk("R7 clear raw", v, 0);
        chk("R8 irq0 low after clear", {31'b0, irq[0]}, 0);
        wr(0, 6, 20);
        rd(0, 1, v); chk("R9 bg load keeps count", v, 10);
        rd(0, 0, v); chk("R9 reload readback", v, 20);
        ticks(3'b001, 10);
        rd(0, 1, v); chk("R9 bg value used at reload", v, 20);
        wr(0, 3, 0);
    endtask

    task automatic t_free();
        logic [31:0] v;
        wr(1, 2, 32'hA0);
        wr(1, 0, 2);
        ticks(3'b010, 2);
        rd(1, 1, v); chk("R4 16-bit wrap", v, 32'h0000_FFFF);
        rd(1, 4, v); chk("R4 raw on 16-bit wrap", v, 1);
        chk("R8 irq1 high", {31'b0, irq[1]}, 1);
        wr(1, 3, 0);
        wr(2, 2, 32'hA2);
        wr(2, 0, 1);
        ticks(3'b100, 1);
        rd(2, 1, v); chk("R4 32-bit wrap", v, 32'hFFFF_FFFF);
        wr(2, 3, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(2, 2, 32'hA3);
        rd(2, 2, v); chk("R13 ctrl readback", v, 32'hA3);
        wr(2, 0, 3);
        ticks(3'b100, 3);
        rd(2, 1, v); chk("R6 one-shot at zero", v, 0);
        rd(2, 4, v); chk("R6 one-shot raw", v, 1);
        wr(2, 3, 0);
        ticks(3'b100, 5);
        rd(2, 4, v); chk("R6 no further raw", v, 0);
        chk("R6 irq2 stays low", {31'b0, irq[2]}, 0);
        rd(2, 1, v); chk("R6 stays zero", v, 0);
        wr(2, 0, 2);
        rd(2, 1, v); chk("R6 load restarts", v, 2);
        ticks(3'b100, 2);
        rd(2, 4, v); chk("R6 second expiry raw", v, 1);
        wr(2, 3, 0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(0, 2, 32'hC6);
        wr(0, 0, 100);
        ticks(3'b001, 15);
        rd(0, 1, v); chk("R3 div16 holds 15 ticks", v, 100);
        ticks(3'b001, 1);
        rd(0, 1, v); chk("R3 div16 step", v, 99);
        wr(0, 2, 32'hCA);
        ticks(3'b001, 255);
        rd(0, 1, v); chk("R3 div256 holds 255 ticks", v, 99);
        ticks(3'b001, 1);
        rd(0, 1, v); chk("R3 div256 step", v, 98);
        wr(0, 2, 32'hC2);
        wr(0, 0, 1);
        ticks(3'b001, 1);
        rd(0, 4, v); chk("R8 raw without ie", v, 1);
        rd(0, 5, v); chk("R8 masked zero without ie", v, 0);
        chk("R8 irq0 low without ie", {31'b0, irq[0]}, 0);
        wr(0, 2, 32'hE2);
        rd(0, 5, v); chk("R8 masked after ie set", v, 1);
        chk("R8 irq0 after ie set", {31'b0, irq[0]}, 1);
        wr(0, 3, 0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(1, 2, 32'h20);
        rd(1, 1, v); chk("R10 off reads zero", v, 0);
        ticks(3'b010, 5);
        wr(1, 2, 32'hA0);
        rd(1, 1, v); chk("R10 count held while off", v, 32'hFFFF);
        wr(1, 1, 32'h1234);
        rd(1, 1, v); chk("R11 value write ignored", v, 32'hFFFF);
    endtask

    task automatic t_indep();
        logic [31:0] v;
        ticks(3'b010, 3);
        rd(1, 1, v); chk("R12 timer1 counted", v, 32'hFFFC);
        rd(0, 1, v); chk("R12 timer0 untouched", v, 1);
        rd(2, 1, v); chk("R12 timer2 untouched", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_free();
        t_oneshot();
        t_prescale();
        t_disable();
        t_indep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule